// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block carries out the complete erase procedure for one block of an on-chip flash array, so that software only has to issue a single command. A one-cycle start pulse captures the block index and the byte addresses of the block's first and last 16-bit words. The sequencer then raises the array's write-enable and opens a guarded erase window, with the watchdog enable covering only that window. Inside the window it brackets the erase pulse with the setup strobe. It then switches the array into verify mode and reads the block back one word at a time, issuing an all-ones dummy write before each read. No pre-write of zeros is performed.

Each wait between strobe changes has its own cycle-count input. If any word reads back with a zero bit, the sequencer leaves verify mode and repeats the erase window. It keeps retrying until the attempt count reaches the programmed limit. It finishes with a one-cycle `done` or `fail` pulse, and `busy` drops in that same cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, every strobe, the block select, the dummy-write request, busy, done and fail are all low.
- R2: A start pulse in idle raises busy and write-enable on the next cycle. Write-enable stays alone, with block select, setup and watchdog enable all low, for `dly_wen_on_i`+1 cycles.
- R3: Block select is one-hot: bit `blk_idx_i`, captured at start, is the only bit set. It is set from the first setup step until the sequence ends, and is all zero while idle.
- R4: Each erase attempt raises watchdog enable and setup together, holds setup alone for `dly_setup_on_i`+1 cycles, and then holds the erase strobe for `dly_pulse_i`+1 cycles. After that comes `dly_pulse_off_i`+1 cycles with setup still high and erase low, then `dly_setup_off_i`+1 cycles with only watchdog enable high. Watchdog enable drops as verify mode rises.
- R5: Verify mode holds for `dly_vfy_on_i`+1 cycles before the first dummy write. Each word then takes one dummy-write cycle, `dly_vfy_read_i`+1 wait cycles and one read cycle. Dummy writes occur only in verify mode. Each verify pass addresses words from the captured start address upward in steps of 2, ending at the captured end address inclusive.
- R6: A word passes only if all 16 read bits are one. The first failing word ends that verify pass at once, so no later address of the block is written.
- R7: The attempt count starts at 1 on each start. A failed verify retries the erase window only while the count is below `retry_max_i`, and a limit of 0 is treated as 1. The number of erase pulses therefore never exceeds max(`retry_max_i`,1).
- R8: After a passing verify, verify mode drops for `dly_vfy_off_i`+1 cycles. Write-enable then drops for `dly_wen_off_i`+1 cycles while busy stays high. Then `done` pulses for one cycle with busy low.
- R9: When the limit is exhausted, the same verify-off and write-enable-off waits occur, and then `fail` pulses for one cycle with busy low. Done and fail are never high together.
- R10: A start pulse while busy has no effect. The running sequence keeps its block, addresses and cycle counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command to begin a block erase |
| blk_idx_i | input | BIDX_W | Index of the block to erase |
| blk_first_i | input | ADDR_W | Byte address of the block's first word |
| blk_last_i | input | ADDR_W | Byte address of the block's last word (inclusive) |
| dly_wen_on_i | input | DLY_W | Wait after write-enable rises |
| dly_wen_off_i | input | DLY_W | Wait after write-enable falls |
| dly_setup_on_i | input | DLY_W | Wait after setup rises |
| dly_setup_off_i | input | DLY_W | Wait after setup falls |
| dly_pulse_i | input | DLY_W | Erase pulse length |
| dly_pulse_off_i | input | DLY_W | Wait after erase strobe falls |
| dly_vfy_on_i | input | DLY_W | Wait after verify mode rises |
| dly_vfy_off_i | input | DLY_W | Wait after verify mode falls |
| dly_vfy_read_i | input | DLY_W | Wait between dummy write and read |
| retry_max_i | input | RETRY_W | Limit on erase attempts |
| rd_data_i | input | DATA_W | Flash read data for the verify address |
| wen_o | output | 1 | Software write-enable strobe |
| setup_o | output | 1 | Erase setup strobe |
| erase_o | output | 1 | Erase pulse strobe |
| vfy_o | output | 1 | Erase-verify mode strobe |
| blk_sel_o | output | NUM_BLOCKS | One-hot block select |
| wdog_en_o | output | 1 | Watchdog enable |
| vfy_addr_o | output | ADDR_W | Verify address |
| dummy_wr_o | output | 1 | Request for an all-ones dummy write to `vfy_addr_o` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: block erased and verified |
| fail_o | output | 1 | One-cycle pulse: attempt limit exhausted |

## Verification
The hardest case to reach is a retry that passes on exactly its last allowed attempt, with the defect in the block's final word. There the address-end test and the attempt-limit test decide on the same read. The bench's flash model holds one chosen word at a value with a single zero bit until a set number of erase pulses has been seen. By placing that word at the end address and making the required pulse count equal the limit, the stimulus drives the sequencer into this corner. Further runs move the defect, lift the limit, zero every delay and fire a second start mid-run. Each run compares strobe widths, pulse counts, dummy-write totals and address order against values computed from the requirements.

// File: rtl/fes_pkg.sv
package fes_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WEN_UP,
      ST_SETUP_UP,
      ST_PULSE,
      ST_PULSE_DN,
      ST_SETUP_DN,
      ST_VFY_UP,
      ST_VFY_WR,
      ST_VFY_WAIT,
      ST_VFY_RD,
      ST_VFY_DN_OK,
      ST_VFY_DN_BAD,
      ST_WEN_DN_OK,
      ST_WEN_DN_BAD
   } seq_state_t;

   function automatic logic in_guard(input seq_state_t s);
      return (s == ST_SETUP_UP) || (s == ST_PULSE) ||
             (s == ST_PULSE_DN) || (s == ST_SETUP_DN);
   endfunction

   function automatic logic in_verify(input seq_state_t s);
      return (s == ST_VFY_UP) || (s == ST_VFY_WR) ||
             (s == ST_VFY_WAIT) || (s == ST_VFY_RD);
   endfunction

endpackage

// File: rtl/fes_delay_timer.sv
module fes_delay_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fes_verify_addr.sv
module fes_verify_addr #(
   parameter int AW   = 16,
   parameter int STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   input  logic [AW-1:0] base_i,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW-1:0] INC = AW'(STEP);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load_i)
         addr_q <= base_i;
      else if (step_i)
         addr_q <= addr_q + INC;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/fes_block_decode.sv
module fes_block_decode #(
   parameter int N  = 16,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          en_i,
   input  logic [IW-1:0] idx_i,
   output logic [N-1:0]  sel_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign sel_o[i] = en_i && (idx_i == IW'(i));
   end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int ADDR_W     = 16,
   parameter int DLY_W      = 16,
   parameter int RETRY_W    = 8,
   parameter int DATA_W     = 16,
   parameter int BIDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [BIDX_W-1:0]     blk_idx_i,
   input  logic [ADDR_W-1:0]     blk_first_i,
   input  logic [ADDR_W-1:0]     blk_last_i,
   input  logic [DLY_W-1:0]      dly_wen_on_i,
   input  logic [DLY_W-1:0]      dly_wen_off_i,
   input  logic [DLY_W-1:0]      dly_setup_on_i,
   input  logic [DLY_W-1:0]      dly_setup_off_i,
   input  logic [DLY_W-1:0]      dly_pulse_i,
   input  logic [DLY_W-1:0]      dly_pulse_off_i,
   input  logic [DLY_W-1:0]      dly_vfy_on_i,
   input  logic [DLY_W-1:0]      dly_vfy_off_i,
   input  logic [DLY_W-1:0]      dly_vfy_read_i,
   input  logic [RETRY_W-1:0]    retry_max_i,
   input  logic [DATA_W-1:0]     rd_data_i,
   output logic                  wen_o,
   output logic                  setup_o,
   output logic                  erase_o,
   output logic                  vfy_o,
   output logic [NUM_BLOCKS-1:0] blk_sel_o,
   output logic                  wdog_en_o,
   output logic [ADDR_W-1:0]     vfy_addr_o,
   output logic                  dummy_wr_o,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  fail_o
);

   localparam int                 WORD_BYTES = DATA_W / 8;
   localparam logic [DATA_W-1:0]  ALL_ONES   = {DATA_W{1'b1}};
   localparam logic [RETRY_W-1:0] ONE_TRY    = RETRY_W'(1);

   // elaboration-time parameter checks
   if (NUM_BLOCKS < 2) begin : g_bad_blocks
      $error("flash_erase_seq: NUM_BLOCKS must be 2 or more");
   end
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
      $error("flash_erase_seq: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 2 || DLY_W < 1) begin : g_bad_width
      $error("flash_erase_seq: ADDR_W or DLY_W too small");
   end
   if (RETRY_W < 2) begin : g_bad_retry
      $error("flash_erase_seq: RETRY_W must be 2 or more");
   end
   if ((1 << BIDX_W) < NUM_BLOCKS) begin : g_bad_bidx
      $error("flash_erase_seq: BIDX_W cannot index every block");
   end

   seq_state_t          state_q, state_d;
   logic [RETRY_W-1:0]  tries_q;
   logic [BIDX_W-1:0]   blk_q;
   logic [ADDR_W-1:0]   first_q, last_q;
   logic                done_q, fail_q;

   logic                tmr_load;
   logic [DLY_W-1:0]    tmr_val;
   logic                tmr_zero;
   logic                addr_load, addr_step;
   logic                take_start, tries_inc, set_done, set_fail;
   logic [RETRY_W-1:0]  try_limit;
   logic                word_ok, at_last, limit_hit;
   logic [ADDR_W-1:0]   cur_addr;

   fes_delay_timer #(.W(DLY_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   fes_verify_addr #(.AW(ADDR_W), .STEP(WORD_BYTES)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (addr_load),
      .step_i (addr_step),
      .base_i (first_q),
      .addr_o (cur_addr)
   );

   fes_block_decode #(.N(NUM_BLOCKS), .IW(BIDX_W)) u_dec (
      .en_i  ((state_q != ST_IDLE) && (state_q != ST_WEN_UP)),
      .idx_i (blk_q),
      .sel_o (blk_sel_o)
   );

   assign try_limit  = (retry_max_i == '0) ? ONE_TRY : retry_max_i;
   assign word_ok    = (rd_data_i == ALL_ONES);
   assign at_last    = (cur_addr >= last_q);
   assign limit_hit  = (tries_q >= try_limit);
   assign take_start = (state_q == ST_IDLE) && start_i;

   // next-state, timer load and address control
   always_comb begin
      state_d   = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      addr_load = 1'b0;
      addr_step = 1'b0;
      tries_inc = 1'b0;
      set_done  = 1'b0;
      set_fail  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_WEN_UP;
               tmr_load = 1'b1;
               tmr_val  = dly_wen_on_i;
            end
         end
         ST_WEN_UP: begin
            if (tmr_zero) begin
               state_d  = ST_SETUP_UP;
               tmr_load = 1'b1;
               tmr_val  = dly_setup_on_i;
            end
         end
         ST_SETUP_UP: begin
            if (tmr_zero) begin
               state_d  = ST_PULSE;
               tmr_load = 1'b1;
               tmr_val  = dly_pulse_i;
            end
         end
         ST_PULSE: begin
            if (tmr_zero) begin
               state_d  = ST_PULSE_DN;
               tmr_load = 1'b1;
               tmr_val  = dly_pulse_off_i;
            end
         end
         ST_PULSE_DN: begin
            if (tmr_zero) begin
               state_d  = ST_SETUP_DN;
               tmr_load = 1'b1;
               tmr_val  = dly_setup_off_i;
            end
         end
         ST_SETUP_DN: begin
            if (tmr_zero) begin
               state_d   = ST_VFY_UP;
               tmr_load  = 1'b1;
               tmr_val   = dly_vfy_on_i;
               addr_load = 1'b1;
            end
         end
         ST_VFY_UP: begin
            if (tmr_zero) begin
               state_d  = ST_VFY_WR;
               tmr_load = 1'b1;
               tmr_val  = '0;
            end
         end
         ST_VFY_WR: begin
            state_d  = ST_VFY_WAIT;
            tmr_load = 1'b1;
            tmr_val  = dly_vfy_read_i;
         end
         ST_VFY_WAIT: begin
            if (tmr_zero) state_d = ST_VFY_RD;
         end
         ST_VFY_RD: begin
            tmr_load = 1'b1;
            if (!word_ok) begin
               state_d = ST_VFY_DN_BAD;
               tmr_val = dly_vfy_off_i;
            end else if (at_last) begin
               state_d = ST_VFY_DN_OK;
               tmr_val = dly_vfy_off_i;
            end else begin
               state_d   = ST_VFY_WR;
               tmr_val   = '0;
               addr_step = 1'b1;
            end
         end
         ST_VFY_DN_OK: begin
            if (tmr_zero) begin
               state_d  = ST_WEN_DN_OK;
               tmr_load = 1'b1;
               tmr_val  = dly_wen_off_i;
            end
         end
         ST_VFY_DN_BAD: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (limit_hit) begin
                  state_d = ST_WEN_DN_BAD;
                  tmr_val = dly_wen_off_i;
               end else begin
                  state_d   = ST_SETUP_UP;
                  tmr_val   = dly_setup_on_i;
                  tries_inc = 1'b1;
               end
            end
         end
         ST_WEN_DN_OK: begin
            if (tmr_zero) begin
               state_d  = ST_IDLE;
               set_done = 1'b1;
            end
         end
         ST_WEN_DN_BAD: begin
            if (tmr_zero) begin
               state_d  = ST_IDLE;
               set_fail = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= set_done;
         fail_q  <= set_fail;
      end
   end

   // command capture and attempt counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q   <= '0;
         first_q <= '0;
         last_q  <= '0;
         tries_q <= '0;
      end else if (take_start) begin
         blk_q   <= blk_idx_i;
         first_q <= blk_first_i;
         last_q  <= blk_last_i;
         tries_q <= ONE_TRY;
      end else if (tries_inc) begin
         tries_q <= tries_q + 1'b1;
      end
   end

   // strobe decode
   assign busy_o     = (state_q != ST_IDLE);
   assign wen_o      = busy_o && (state_q != ST_WEN_DN_OK) && (state_q != ST_WEN_DN_BAD);
   assign wdog_en_o  = in_guard(state_q);
   assign setup_o    = in_guard(state_q) && (state_q != ST_SETUP_DN);
   assign erase_o    = (state_q == ST_PULSE);
   assign vfy_o      = in_verify(state_q);
   assign dummy_wr_o = (state_q == ST_VFY_WR);
   assign vfy_addr_o = cur_addr;
   assign done_o     = done_q;
   assign fail_o     = fail_q;

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
   parameter int NUM_BLOCKS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  wen_o,
   input logic                  setup_o,
   input logic                  erase_o,
   input logic                  vfy_o,
   input logic [NUM_BLOCKS-1:0] blk_sel_o,
   input logic                  wdog_en_o,
   input logic                  dummy_wr_o,
   input logic                  busy_o,
   input logic                  done_o,
   input logic                  fail_o
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(blk_sel_o)); // R3
   AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (blk_sel_o == '0)); // R3
   AST_START_WEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (wen_o && !setup_o && !wdog_en_o && blk_sel_o == '0)); // R2
   AST_PULSE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      erase_o |-> (setup_o && wdog_en_o && wen_o)); // R4
   AST_SETUP_UNDER_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
      setup_o |-> wdog_en_o); // R4
   AST_VFY_APART: assert property (@(posedge clk) disable iff (!rst_n)
      vfy_o |-> (!setup_o && !wdog_en_o && wen_o)); // R5
   AST_DUMMY_IN_VFY: assert property (@(posedge clk) disable iff (!rst_n)
      dummy_wr_o |-> vfy_o); // R5
   AST_DUMMY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      dummy_wr_o |=> !dummy_wr_o); // R5
   AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |-> !busy_o); // R8
   AST_END_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |-> $past(busy_o)); // R8
   AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o)); // R9
   AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o || fail_o)); // R10

endmodule

bind flash_erase_seq fes_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .wen_o      (wen_o),
   .setup_o    (setup_o),
   .erase_o    (erase_o),
   .vfy_o      (vfy_o),
   .blk_sel_o  (blk_sel_o),
   .wdog_en_o  (wdog_en_o),
   .dummy_wr_o (dummy_wr_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .fail_o     (fail_o)
);

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;

   localparam int NB = 16;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int TW = 16;
   localparam int RW = 8;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [BW-1:0] idx = '0;
   logic [AW-1:0] first_a = '0, last_a = '0;
   logic [RW-1:0] lim = '0;
   logic [DW-1:0] rdata;
   logic          wen, setup, erase, vfy, wdog, dummy, busy, done, fail;
   logic [NB-1:0] sel;
   logic [AW-1:0] vaddr;

   int d_won = 3, d_woff = 2, d_son = 4, d_soff = 1, d_pul = 6;
   int d_poff = 2, d_von = 3, d_voff = 2, d_vrd = 1;

   int n_tot = 0, n_bad = 0;

   // flash model and monitor state
   int  cur_first = 0, cur_idx = 0, bad_addr = -1, need = 0, pulse_base = 0;
   int  m_pulses = 0, m_erase = 0, m_wdog = 0, m_setup = 0, m_vfy = 0, m_dw = 0;
   int  m_pre = 0, m_post = 0, m_busy = 0, m_selok = 0, m_selbad = 0, m_addrerr = 0;
   int  exp_addr = 0, last_dw = 0;
   logic p_erase = 1'b0, p_vfy = 1'b0;

   always #4 clk = ~clk;

   flash_erase_seq #(.NUM_BLOCKS(NB), .ADDR_W(AW), .DLY_W(TW), .RETRY_W(RW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .blk_idx_i(idx),
      .blk_first_i(first_a), .blk_last_i(last_a),
      .dly_wen_on_i(TW'(d_won)), .dly_wen_off_i(TW'(d_woff)),
      .dly_setup_on_i(TW'(d_son)), .dly_setup_off_i(TW'(d_soff)),
      .dly_pulse_i(TW'(d_pul)), .dly_pulse_off_i(TW'(d_poff)),
      .dly_vfy_on_i(TW'(d_von)), .dly_vfy_off_i(TW'(d_voff)),
      .dly_vfy_read_i(TW'(d_vrd)), .retry_max_i(lim), .rd_data_i(rdata),
      .wen_o(wen), .setup_o(setup), .erase_o(erase), .vfy_o(vfy),
      .blk_sel_o(sel), .wdog_en_o(wdog), .vfy_addr_o(vaddr), .dummy_wr_o(dummy),
      .busy_o(busy), .done_o(done), .fail_o(fail)
   );

   // defective word reads with one zero bit until enough erase pulses were seen
   always_comb begin
      if (bad_addr >= 0 && int'(vaddr) == bad_addr && (m_pulses - pulse_base) < need)
         rdata = 16'hFFFE;
      else
         rdata = 16'hFFFF;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (erase && !p_erase) m_pulses++;
         if (erase) m_erase++;
         if (wdog)  m_wdog++;
         if (setup) m_setup++;
         if (vfy)   m_vfy++;
         if (busy)  m_busy++;
         if (busy && wen && sel == '0) m_pre++;
         if (busy && !wen) m_post++;
         if (sel == (NB'(1) << cur_idx)) m_selok++;
         else if (sel != '0) m_selbad++;
         if (vfy && !p_vfy) exp_addr = cur_first;
         if (dummy) begin
            m_dw++;
            if (int'(vaddr) != exp_addr) m_addrerr++;
            last_dw = int'(vaddr);
            exp_addr += 2;
         end
         p_erase = erase;
         p_vfy   = vfy;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // run one erase command and compare against values derived from the requirements
   task automatic exec_and_check(input string name, input int bidx, input int fa, input int la,
                                 input int limit, input int badw, input int nd, input bit disturb);
      int words, kb, eff, tries, failed, exp_dw, exp_vfy, per_try, exp_busy, got, cyc;
      int b_p, b_e, b_w, b_s, b_v, b_d, b_pre, b_post, b_busy, b_ok, b_bad, b_ae;
      bit pass;
      words = (la - fa) / 2 + 1;
      eff   = (limit == 0) ? 1 : limit;
      if (badw < 0 || nd == 0) begin pass = 1; tries = 1; kb = 0; end
      else begin
         kb = (badw - fa) / 2;
         pass  = (nd <= eff);
         tries = pass ? nd : eff;
      end
      failed   = pass ? tries - 1 : tries;
      exp_dw   = failed * (kb + 1) + (pass ? words : 0);
      exp_vfy  = tries * (d_von + 1) + exp_dw * (d_vrd + 3);
      per_try  = d_son + d_pul + d_poff + d_soff + 4;
      exp_busy = (d_won + 1) + tries * per_try + exp_vfy + tries * (d_voff + 1) + (d_woff + 1);

      @(negedge clk);
      b_p = m_pulses; b_e = m_erase; b_w = m_wdog; b_s = m_setup; b_v = m_vfy; b_d = m_dw;
      b_pre = m_pre; b_post = m_post; b_busy = m_busy; b_ok = m_selok; b_bad = m_selbad;
      b_ae = m_addrerr;
      cur_first = fa; cur_idx = bidx; bad_addr = badw; need = nd; pulse_base = m_pulses;
      idx = BW'(bidx); first_a = AW'(fa); last_a = AW'(la); lim = RW'(limit);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && wen, "R2", {name, " busy+wen after start"}, {busy, wen}, 3);
      if (disturb) begin
         repeat (5) @(negedge clk);
         idx = BW'(bidx ^ 1); first_a = AW'(fa + 64); last_a = AW'(la + 64); lim = RW'(limit);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      got = 0; cyc = 0;
      while (got == 0 && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (done || fail) begin
            got = done ? 1 : 2;
            chk(!busy, pass ? "R8" : "R9", {name, " busy low with end pulse"}, busy, 0);
            chk(!(done && fail), "R9", {name, " done/fail exclusive"}, {done, fail}, pass ? 2 : 1);
         end
      end
      @(negedge clk);
      chk(got == (pass ? 1 : 2), pass ? "R8" : "R9", {name, " result 1=done 2=fail"}, got, pass ? 1 : 2);
      chk(!done && !fail && !busy, "R8", {name, " end pulse one cycle"}, {done, fail}, 0);
      chk(m_pulses - b_p == tries, "R7", {name, " erase pulses"}, m_pulses - b_p, tries);
      chk(m_erase - b_e == tries * (d_pul + 1), "R4", {name, " erase strobe cycles"},
          m_erase - b_e, tries * (d_pul + 1));
      chk(m_setup - b_s == tries * (d_son + d_pul + d_poff + 3), "R4", {name, " setup cycles"},
          m_setup - b_s, tries * (d_son + d_pul + d_poff + 3));
      chk(m_wdog - b_w == tries * per_try, "R4", {name, " watchdog cycles"}, m_wdog - b_w, tries * per_try);
      chk(m_pre - b_pre == d_won + 1, "R2", {name, " write-enable lead"}, m_pre - b_pre, d_won + 1);
      chk(m_post - b_post == d_woff + 1, pass ? "R8" : "R9", {name, " write-enable tail"},
          m_post - b_post, d_woff + 1);
      chk(m_dw - b_d == exp_dw, "R6", {name, " dummy writes"}, m_dw - b_d, exp_dw);
      chk(m_vfy - b_v == exp_vfy, "R5", {name, " verify cycles"}, m_vfy - b_v, exp_vfy);
      chk(m_addrerr - b_ae == 0, "R5", {name, " address order errors"}, m_addrerr - b_ae, 0);
      chk(m_busy - b_busy == exp_busy, disturb ? "R10" : "R8", {name, " busy cycles"},
          m_busy - b_busy, exp_busy);
      chk(m_selbad - b_bad == 0 && (m_selok - b_ok) >= exp_busy - (d_won + 1), "R3",
          {name, " one-hot select cycles"}, m_selok - b_ok, exp_busy - (d_won + 1));
      if (pass)
         chk(last_dw == la, "R5", {name, " last word verified"}, last_dw, la);
      bad_addr = -1;
   endtask

   task automatic t_reset;
      chk(!wen && !setup && !erase && !vfy && !wdog && !dummy && !busy && !done && !fail && sel == '0,
          "R1", "outputs quiet in reset", {wen, setup, erase, vfy, busy, done, fail}, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !wen && sel == '0 && !done && !fail, "R1", "idle after reset", {busy, wen, done, fail}, 0);
   endtask

   task automatic t_clean_pass;
      exec_and_check("clean", 3, 'h100, 'h10E, 4, -1, 0, 0);
   endtask

   task automatic t_retry_pass;
      exec_and_check("retry", 5, 'h200, 'h21E, 3, 'h208, 2, 0);
   endtask

   task automatic t_limit_fail;
      exec_and_check("limit", 9, 'h400, 'h40E, 3, 'h402, 10, 0);
   endtask

   task automatic t_zero_limit;
      exec_and_check("zero-limit", 0, 'h40, 'h46, 0, 'h40, 5, 0);
   endtask

   task automatic t_last_word;
      exec_and_check("last-word", 15, 'h800, 'h80C, 2, 'h80C, 2, 0);
   endtask

   task automatic t_single_word;
      exec_and_check("single", 1, 'h20, 'h20, 2, -1, 0, 0);
   endtask

   task automatic t_busy_start;
      exec_and_check("busy-start", 6, 'h300, 'h306, 2, 'h304, 2, 1);
      repeat (4) @(negedge clk);
      chk(!busy, "R10", "no restart after ignored start", busy, 0);
   endtask

   task automatic t_zero_delays;
      d_won = 0; d_woff = 0; d_son = 0; d_soff = 0; d_pul = 0;
      d_poff = 0; d_von = 0; d_voff = 0; d_vrd = 0;
      exec_and_check("zero-delay", 12, 'h1000, 'h1006, 3, 'h1002, 2, 0);
      d_won = 3; d_woff = 2; d_son = 4; d_soff = 1; d_pul = 6;
      d_poff = 2; d_von = 3; d_voff = 2; d_vrd = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tot++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_clean_pass();
      t_retry_pass();
      t_limit_fail();
      t_zero_limit();
      t_last_word();
      t_single_word();
      t_busy_start();
      t_zero_delays();
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   end

endmodule